// File: doc/BRIEF.md
# Transition-Signalled Handshake Pipeline

This block carries data words from a producer to a consumer through a short chain of holding stages. Handshaking uses two-phase transition signalling: the producer flips its request line when it offers a new word, and each side shows acceptance by flipping its acknowledge line to match. A request and an acknowledge at the same level mean the channel is idle. Levels that differ mean a word is waiting. Each transfer therefore takes two signal events and never needs a return-to-zero phase.

Each stage is controlled by a Muller C-element. One input of the element is the request arriving from the stage before it. The other is the inverted phase of the stage after it. When the two agree, the element fires. The stage then latches the word and toggles its own phase. That toggle acknowledges the previous stage and also acts as the request to the next stage. A stage can take a new word only after its successor has captured the word it holds. If the consumer never acknowledges, words keep moving forward until every stage is full, and then the producer stalls.

The element is modelled as an equivalent clocked circuit with reset, so the whole chain is synchronous logic. With an empty chain, a word moves forward by one stage per clock.

Top module: `tphs_pipe`

## Requirements
- R1: While reset is active and after its release, `in_ack`, `out_req` and `out_data` are all zero.
- R2: In an empty pipeline, a toggle of `in_req` is acknowledged at the first rising clock edge: after that edge, `in_ack` equals `in_req`.
- R3: A word entering an empty pipeline produces an `out_req` toggle exactly DEPTH clock edges after the `in_req` toggle. At that point `out_data` carries the word.
- R4: Words leave in the order they were accepted. No word is lost and no word is duplicated.
- R5: If `out_ack` is never toggled, the pipeline accepts exactly DEPTH words. The next request then stays unacknowledged, and the number of stored words never exceeds DEPTH.
- R6: While `out_req` differs from `out_ack` (the output stage is full), `out_data` does not change.
- R7: `in_ack` changes only to the value that `in_req` had at that clock edge.
- R8: `out_req` toggles only at an edge where it was equal to `out_ack`, that is, only into an empty output stage.
- R9: Once a full pipeline receives an `out_ack` toggle, a stalled input request is acknowledged within DEPTH clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the clocked model of the C-elements |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 1 | Producer request; a toggle offers the word on `in_data` |
| in_data | input | WIDTH | Producer word; held stable until `in_ack` matches `in_req` |
| in_ack | output | 1 | Acknowledge to the producer; becomes equal to `in_req` when the word is captured |
| out_req | output | 1 | Request to the consumer; toggles when a new word is on `out_data` |
| out_data | output | WIDTH | Word held by the last stage |
| out_ack | input | 1 | Consumer acknowledge; the consumer toggles it to match `out_req` to free the last stage |

## Verification
The assertions check the per-cycle protocol rules on every clock. These rules are: output data stays stable while the last stage is full, `in_ack` only moves toward `in_req`, `out_req` only toggles into an empty output stage, and an occupancy count of accepted minus released words never exceeds DEPTH. Some properties only show up across a run of events, and the bench scenarios cover those: the exact DEPTH-edge latency through an empty chain, the stall after DEPTH unacknowledged words, the resume after a single acknowledge, and the end-to-end order and completeness of words under random producer and consumer timing.

// File: rtl/tphs_pkg.sv
package tphs_pkg;

   // Occupancy of one stage, derived from its two phase bits
   typedef enum logic {
      SLOT_EMPTY = 1'b0,
      SLOT_FULL  = 1'b1
   } slot_state_e;

   // A stage is full when its own phase differs from the phase of its successor
   function automatic slot_state_e slot_state(input logic own_ph, input logic next_ph);
      return (own_ph != next_ph) ? SLOT_FULL : SLOT_EMPTY;
   endfunction

   // The C-element fires when both inputs agree and differ from its stored output
   function automatic logic celem_fires(input logic a, input logic b, input logic c);
      return (a == b) && (c != a);
   endfunction

endpackage

// File: rtl/tphs_celem.sv
// Clocked equivalent of a Muller C-element whose second input is inverted.
// Input a is the incoming request phase. Input b_n is the phase of the next stage.
module tphs_celem (
   input  logic clk,
   input  logic rst_n,
   input  logic a,
   input  logic b_n,
   output logic c,
   output logic fire
);
   import tphs_pkg::*;

   logic b;

   assign b    = ~b_n;
   assign fire = celem_fires(a, b, c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c <= 1'b0;
      end else if (fire) begin
         c <= a;
      end
   end

endmodule

// File: rtl/tphs_stage.sv
// One capture/pass stage: C-element control plus a word register that loads on firing.
module tphs_stage #(
   parameter int WIDTH    = 24,
   parameter bit DATA_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             nxt_ph_i,
   input  logic [WIDTH-1:0] d_i,
   output logic             req_o,
   output logic [WIDTH-1:0] q_o
);
   logic cap;

   tphs_celem u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (req_i),
      .b_n   (nxt_ph_i),
      .c     (req_o),
      .fire  (cap)
   );

   generate
      if (DATA_RST) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_o <= '0;
            end else if (cap) begin
               q_o <= d_i;
            end
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            if (cap) begin
               q_o <= d_i;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tphs_pipe.sv
// Chain of DEPTH transition-signalled stages.
module tphs_pipe #(
   parameter int WIDTH    = 24,
   parameter int DEPTH    = 4,
   parameter bit DATA_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_req,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ack,
   output logic             out_req,
   output logic [WIDTH-1:0] out_data,
   input  logic             out_ack
);
   localparam int LAST = DEPTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("tphs_pipe: WIDTH must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("tphs_pipe: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] ph;
   logic [WIDTH-1:0] word [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         logic             req_src;
         logic             nxt_src;
         logic [WIDTH-1:0] d_src;

         if (i == 0) begin : g_head
            assign req_src = in_req;
            assign d_src   = in_data;
         end else begin : g_body
            assign req_src = ph[i-1];
            assign d_src   = word[i-1];
         end

         if (i == LAST) begin : g_tail
            assign nxt_src = out_ack;
         end else begin : g_inner
            assign nxt_src = ph[i+1];
         end

         tphs_stage #(
            .WIDTH    (WIDTH),
            .DATA_RST (DATA_RST)
         ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_src),
            .nxt_ph_i (nxt_src),
            .d_i      (d_src),
            .req_o    (ph[i]),
            .q_o      (word[i])
         );
      end
   endgenerate

   assign in_ack   = ph[0];
   assign out_req  = ph[LAST];
   assign out_data = word[LAST];

endmodule

// File: rtl/tphs_pipe_chk.sv
module tphs_pipe_chk #(
   parameter int WIDTH = 24,
   parameter int DEPTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_req,
   input logic             in_ack,
   input logic             out_req,
   input logic [WIDTH-1:0] out_data,
   input logic             out_ack
);
   localparam int CW = $clog2(DEPTH + 2) + 1;

   logic          in_ack_q;
   logic          out_ack_q;
   logic [CW-1:0] occ;

   // Occupancy: words acknowledged on the input minus words released by the consumer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_ack_q  <= 1'b0;
         out_ack_q <= 1'b0;
         occ       <= '0;
      end else begin
         in_ack_q  <= in_ack;
         out_ack_q <= out_ack;
         occ       <= occ + CW'(in_ack != in_ack_q) - CW'(out_ack != out_ack_q);
      end
   end

   assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req != out_ack) |=> $stable(out_data));

   assert_ack_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(in_ack) |-> (in_ack == $past(in_req)));

   assert_out_into_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_req) |-> $past(out_req == out_ack));

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (!in_ack && !out_req));

endmodule

bind tphs_pipe tphs_pipe_chk #(
   .WIDTH (WIDTH),
   .DEPTH (DEPTH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_req   (in_req),
   .in_ack   (in_ack),
   .out_req  (out_req),
   .out_data (out_data),
   .out_ack  (out_ack)
);

// File: tb/tb_tphs_pipe.sv
`timescale 1ns/1ps
module tb_tphs_pipe;
   localparam int W = 24;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_req = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ack;
   logic         out_req;
   logic [W-1:0] out_data;
   logic         out_ack = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int n_acc = 0;
   int n_del = 0;
   logic [W-1:0] mq[$];

   always #2.5 clk = ~clk;

   tphs_pipe #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
      .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Behavioural reference: queue of accepted words, compared on every clock
   logic pa = 1'b0, pr = 1'b0;
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (in_ack != pa) begin
            check(in_ack == in_req, "R7", in_ack, in_req);
            mq.push_back(in_data);
            n_acc++;
         end
         if (out_req != pr) begin
            check(pr == out_ack, "R8", pr, out_ack);
            if (mq.size() == 0) begin
               check(1'b0, "R4 duplicate", out_data, 0);
            end else begin
               check(out_data == mq[0], "R4 order", out_data, mq[0]);
               void'(mq.pop_front());
            end
            n_del++;
         end
      end
      pa = in_ack;
      pr = out_req;
   end

   task automatic send(input logic [W-1:0] v, input int limit, output bit ok);
      in_data = v;
      in_req  = ~in_req;
      ok = 1'b0;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (in_ack == in_req) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic drain();
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (out_req != out_ack) out_ack = ~out_ack;
         if (mq.size() == 0 && out_req == out_ack && in_ack == in_req) break;
      end
      repeat (D + 2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      bit ok;
      logic [W-1:0] first;
      int tot;
      repeat (3) @(negedge clk);
      check(in_ack == 0 && out_req == 0 && out_data == 0, "R1 in reset", out_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ack == 0 && out_req == 0 && out_data == 0, "R1 after release", out_data, 0);

      // Latency through an empty chain
      in_data = 24'hA5C31E;
      in_req  = ~in_req;
      @(negedge clk);
      check(in_ack == in_req, "R2", in_ack, in_req);
      repeat (D - 2) @(negedge clk);
      check(out_req == 1'b0, "R3 early", out_req, 0);
      @(negedge clk);
      check(out_req == 1'b1, "R3 toggle", out_req, 1);
      check(out_data == 24'hA5C31E, "R3 data", out_data, 24'hA5C31E);
      out_ack = ~out_ack;
      drain();

      // Fill with the consumer idle
      tot = 0;
      for (int i = 0; i < D; i++) begin
         send(24'h100 + 24'(i), 12, ok);
         if (ok) tot++;
      end
      check(tot == D, "R5 accepted", tot, D);
      first = out_data;
      check(first == 24'h100, "R4 head", first, 24'h100);
      send(24'h1FF, 12, ok);
      check(!ok, "R5 stall", ok, 0);
      check(out_data == first, "R6 stable", out_data, first);
      check(in_ack != in_req, "R5 unacked", in_ack, ~in_req);
      // One acknowledge frees a slot
      out_ack = ~out_ack;
      ok = 1'b0;
      for (int k = 0; k < D; k++) begin
         @(negedge clk);
         if (in_ack == in_req) ok = 1'b1;
      end
      check(ok, "R9 resume", ok, 1);
      drain();
      check(mq.size() == 0, "R4 drained", mq.size(), 0);
      check(n_acc == n_del, "R4 count", n_del, n_acc);

      // Random producer and consumer timing
      fork
         begin
            for (int i = 0; i < 300; i++) begin
               repeat ($urandom_range(0, 3)) @(negedge clk);
               send(W'($urandom), 1000, ok);
            end
         end
         begin
            for (int j = 0; j < 300; j++) begin
               do @(negedge clk); while (out_req == out_ack || ($urandom % 3) == 0);
               out_ack = ~out_ack;
            end
         end
      join
      repeat (D + 2) @(negedge clk);
      check(mq.size() == 0, "R4 random lost", mq.size(), 0);
      check(n_acc == n_del && n_acc == 306, "R4 random count", n_del, 306);
      check(out_req == out_ack && in_ack == in_req, "R4 idle", out_req, out_ack);
      summary();
   end
endmodule